// File: doc/BRIEF.md
# Four-bit arithmetic/logic unit core

A purely combinational arithmetic/logic unit that follows the classic sixteen-by-two function table. Two operands, a four-bit function select, a mode bit and a carry input produce a result, a carry output, the group generate and group propagate terms used by an external lookahead stage, and a flag that is high when every result bit is one. The block holds no state, so every output follows its inputs within the same cycle.

Every function is built from two per-bit terms. The first addend X is chosen by the two low select bits: A, A|B, A|~B or all ones. The second addend Y is chosen by the two high select bits: zero, A&~B, A&B or A. Arithmetic mode adds X, Y and the carry input. Logic mode returns the complement of X^Y for each bit and ignores the carry chain. Group propagate leaves the block in true polarity, and the carry output term reuses the same AND of the per-bit X terms that forms it.

The width is the parameter `NBITS` (default 4). The carry network is either flattened lookahead or ripple, picked by the parameter `CARRY_STYLE`.

Top module: `alu4_core`

## Requirements
- R1: With `logic_mode`=1, `result` for `fsel` 0..15 is ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A. Here `fsel` bit 0 is the lowest select bit.
- R2: With `logic_mode`=0, `result` is the low NBITS bits of X+Y+`carry_in`. X is A, A|B, A|~B or all ones for `fsel[1:0]` = 0, 1, 2 or 3. Y is 0, A&~B, A&B or A for `fsel[3:2]` = 0, 1, 2 or 3.
- R3: With `logic_mode`=0 and `fsel`=9, `{carry_out,result}` equals A+B+`carry_in`.
- R4: With `logic_mode`=1, `carry_in` has no effect on `result`.
- R5: `carry_out` is bit NBITS of X+Y+`carry_in`, with X and Y as in R2, in both modes. It is 0 whenever the sum fits in NBITS bits.
- R6: `grp_gen` is bit NBITS of X+Y, taken with no carry input.
- R7: `grp_prop` is active high and is 1 exactly when X is all ones. In addition, `carry_out` = `grp_gen` | (`grp_prop` & `carry_in`).
- R8: `a_eq_b` is 1 exactly when every `result` bit is 1. With `logic_mode`=0, `fsel`=6 and `carry_in`=0, it is therefore 1 exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | NBITS | Operand A |
| opb | input | NBITS | Operand B |
| fsel | input | 4 | Function select |
| logic_mode | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| carry_in | input | 1 | Active-high carry into bit 0 |
| result | output | NBITS | Function result |
| carry_out | output | 1 | Active-high carry out of the top bit |
| grp_prop | output | 1 | Group propagate, true polarity |
| grp_gen | output | 1 | Group generate |
| a_eq_b | output | 1 | High when every result bit is one |

## Verification
The bench builds the block with its default parameters: NBITS=4 and the flattened lookahead carry network. At that width all 2^14 combinations of operands, select, mode and carry fit in one exhaustive sweep. The sweep covers every row of both function tables and every carry boundary, including all-ones plus one and the equality compare of each operand pair. The ripple variant has the same port behaviour and could be reached by overriding `CARRY_STYLE`, but this bench does not build it.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int SEL_W = 4;

   typedef enum logic [0:0] {
      CARRY_RIPPLE    = 1'b0,
      CARRY_LOOKAHEAD = 1'b1
   } carry_style_e;
endpackage

// File: rtl/alu_bit_terms.sv
// Per-bit operand terms: x is the first addend bit (propagate), y the second (generate).
module alu_bit_terms
   import alu_pkg::*;
(
   input  logic             a_i,
   input  logic             b_i,
   input  logic [SEL_W-1:0] sel,
   output logic             x_o,
   output logic             y_o
);
   logic a_n, b_n, x_n, y_n;

   // Gate network works on complemented operands.
   always_comb begin
      a_n = ~a_i;
      b_n = ~b_i;
      x_n = a_n & ~(b_i & sel[0]) & ~(b_n & sel[1]);
      y_n = ~((~a_n & b_n & sel[2]) | (~a_n & ~b_n & sel[3]));
      x_o = ~x_n;
      y_o = ~y_n;
   end
endmodule

// File: rtl/alu_carry_net.sv
// Carry network: internal carries, group generate/propagate and carry out.
module alu_carry_net
   import alu_pkg::*;
#(
   parameter int           NBITS       = 4,
   parameter carry_style_e CARRY_STYLE = CARRY_LOOKAHEAD
) (
   input  logic [NBITS-1:0] x,
   input  logic [NBITS-1:0] y,
   input  logic             ci,
   output logic [NBITS-1:0] cvec,
   output logic             gen_o,
   output logic             prop_o,
   output logic             cout_o
);
   generate
      if (CARRY_STYLE == CARRY_LOOKAHEAD) begin : g_lookahead
         always_comb begin
            logic acc, run;
            for (int i = 0; i < NBITS; i++) begin
               acc = 1'b0;
               for (int j = 0; j < i; j++) begin
                  run = y[j];
                  for (int k = j + 1; k < i; k++) run = run & x[k];
                  acc = acc | run;
               end
               run = ci;
               for (int k = 0; k < i; k++) run = run & x[k];
               cvec[i] = acc | run;
            end
            acc = 1'b0;
            for (int j = 0; j < NBITS; j++) begin
               run = y[j];
               for (int k = j + 1; k < NBITS; k++) run = run & x[k];
               acc = acc | run;
            end
            gen_o  = acc;
            prop_o = &x;
            // carry-out product term shares the propagate AND
            cout_o = gen_o | (prop_o & ci);
         end
      end else begin : g_ripple
         logic [NBITS:0] chain, gchain;
         always_comb begin
            chain[0]  = ci;
            gchain[0] = 1'b0;
            for (int i = 0; i < NBITS; i++) begin
               chain[i+1]  = y[i] | (x[i] & chain[i]);
               gchain[i+1] = y[i] | (x[i] & gchain[i]);
            end
            cvec   = chain[NBITS-1:0];
            gen_o  = gchain[NBITS];
            prop_o = &x;
            cout_o = chain[NBITS];
         end
      end
   endgenerate
endmodule

// File: rtl/alu_result_stage.sv
// Result stage: half sums, mode gating, complemented result, all-ones flag.
module alu_result_stage #(
   parameter int NBITS = 4
) (
   input  logic [NBITS-1:0] x,
   input  logic [NBITS-1:0] y,
   input  logic [NBITS-1:0] cvec,
   input  logic             mode,
   output logic [NBITS-1:0] f_o,
   output logic             ones_o
);
   logic [NBITS-1:0] half, f_n;

   generate
      for (genvar i = 0; i < NBITS; i++) begin : g_bit
         always_comb begin
            half[i] = x[i] ^ y[i];
            // logic mode blocks the carry path; result formed inverted first
            f_n[i]  = mode ? half[i] : ~(half[i] ^ cvec[i]);
         end
      end
   endgenerate

   always_comb begin
      f_o    = ~f_n;
      ones_o = &f_o;
   end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
   import alu_pkg::*;
#(
   parameter int           NBITS       = 4,
   parameter carry_style_e CARRY_STYLE = CARRY_LOOKAHEAD
) (
   input  logic [NBITS-1:0] opa,
   input  logic [NBITS-1:0] opb,
   input  logic [3:0]       fsel,
   input  logic             logic_mode,
   input  logic             carry_in,
   output logic [NBITS-1:0] result,
   output logic             carry_out,
   output logic             grp_prop,
   output logic             grp_gen,
   output logic             a_eq_b
);
   generate
      if (NBITS < 1 || NBITS > 32) begin : g_bad_width
         $error("alu4_core: NBITS must lie in 1..32");
      end
      if (SEL_W != 4) begin : g_bad_sel
         $error("alu4_core: select width must be 4");
      end
   endgenerate

   logic [NBITS-1:0] xt, yt, cv;

   generate
      for (genvar i = 0; i < NBITS; i++) begin : g_terms
         alu_bit_terms u_terms (
            .a_i (opa[i]),
            .b_i (opb[i]),
            .sel (fsel),
            .x_o (xt[i]),
            .y_o (yt[i])
         );
      end
   endgenerate

   alu_carry_net #(.NBITS(NBITS), .CARRY_STYLE(CARRY_STYLE)) u_carry (
      .x      (xt),
      .y      (yt),
      .ci     (carry_in),
      .cvec   (cv),
      .gen_o  (grp_gen),
      .prop_o (grp_prop),
      .cout_o (carry_out)
   );

   alu_result_stage #(.NBITS(NBITS)) u_result (
      .x      (xt),
      .y      (yt),
      .cvec   (cv),
      .mode   (logic_mode),
      .f_o    (result),
      .ones_o (a_eq_b)
   );
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
   parameter int NBITS = 4
) (
   input logic [NBITS-1:0] opa,
   input logic [NBITS-1:0] opb,
   input logic [3:0]       fsel,
   input logic             logic_mode,
   input logic             carry_in,
   input logic [NBITS-1:0] result,
   input logic             carry_out,
   input logic             grp_prop,
   input logic             grp_gen,
   input logic             a_eq_b
);
   always_comb begin
      if (!$isunknown({opa, opb, fsel, logic_mode, carry_in})) begin
         a_r8_flag_all_ones: assert (a_eq_b == (result == {NBITS{1'b1}}));
         a_r7_cout_lookahead: assert (carry_out == (grp_gen | (grp_prop & carry_in)));
         a_r6_gen_forces_cout: assert (!grp_gen || carry_out);
         if (!logic_mode && fsel == 4'd9) begin
            a_r3_add: assert ({carry_out, result} ==
                              ({1'b0, opa} + {1'b0, opb} + {{NBITS{1'b0}}, carry_in}));
         end
         if (logic_mode && fsel == 4'd6) begin
            a_r1_logic_xor: assert (result == (opa ^ opb));
         end
         if (logic_mode && fsel == 4'd12) begin
            a_r1_logic_ones: assert (result == {NBITS{1'b1}});
         end
      end
   end
endmodule

bind alu4_core alu4_core_chk #(.NBITS(NBITS)) u_alu4_core_chk (
   .opa        (opa),
   .opb        (opb),
   .fsel       (fsel),
   .logic_mode (logic_mode),
   .carry_in   (carry_in),
   .result     (result),
   .carry_out  (carry_out),
   .grp_prop   (grp_prop),
   .grp_gen    (grp_gen),
   .a_eq_b     (a_eq_b)
);

// File: tb/test_alu4_core.sv
module test_alu4_core;
   localparam int CLK_PERIOD = 10;
   localparam int NB         = 4;
   localparam int NVEC       = 1 << (2*NB + 6);
   localparam int WATCHDOG   = NVEC + 1000;

   typedef struct packed {
      logic [NB-1:0] a;
      logic [NB-1:0] b;
      logic [3:0]    sel;
      logic          mode;
      logic          ci;
      logic [NB-1:0] f;
      logic          cout;
      logic          g;
      logic          p;
      logic          eq;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NB-1:0] opa = '0, opb = '0;
   logic [3:0]    fsel = '0;
   logic          logic_mode = 1'b0, carry_in = 1'b0;
   logic [NB-1:0] result;
   logic          carry_out, grp_prop, grp_gen, a_eq_b;

   int total = 0;
   int bad   = 0;
   bit driver_done = 1'b0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   alu4_core i_alu4_core (
      .opa(opa), .opb(opb), .fsel(fsel), .logic_mode(logic_mode),
      .carry_in(carry_in), .result(result), .carry_out(carry_out),
      .grp_prop(grp_prop), .grp_gen(grp_gen), .a_eq_b(a_eq_b)
   );

   function automatic exp_t model(logic [NB-1:0] a, logic [NB-1:0] b,
                                  logic [3:0] sel, logic mode, logic ci);
      exp_t e;
      logic [NB-1:0] x, y, lf;
      logic [NB:0]   s, s0;
      case (sel[1:0])
         2'd0: x = a;
         2'd1: x = a | b;
         2'd2: x = a | ~b;
         default: x = '1;
      endcase
      case (sel[3:2])
         2'd0: y = '0;
         2'd1: y = a & ~b;
         2'd2: y = a & b;
         default: y = a;
      endcase
      case (sel)
         4'd0:  lf = ~a;
         4'd1:  lf = ~(a | b);
         4'd2:  lf = ~a & b;
         4'd3:  lf = '0;
         4'd4:  lf = ~(a & b);
         4'd5:  lf = ~b;
         4'd6:  lf = a ^ b;
         4'd7:  lf = a & ~b;
         4'd8:  lf = ~a | b;
         4'd9:  lf = ~(a ^ b);
         4'd10: lf = b;
         4'd11: lf = a & b;
         4'd12: lf = '1;
         4'd13: lf = a | ~b;
         4'd14: lf = a | b;
         default: lf = a;
      endcase
      s  = {1'b0, x} + {1'b0, y} + {{NB{1'b0}}, ci};
      s0 = {1'b0, x} + {1'b0, y};
      e.a = a; e.b = b; e.sel = sel; e.mode = mode; e.ci = ci;
      e.f    = mode ? lf : s[NB-1:0];
      e.cout = s[NB];
      e.g    = s0[NB];
      e.p    = (x == '1);
      e.eq   = (e.f == '1);
      return e;
   endfunction

   task automatic check1(string tag, int act, int exp_v);
      total++;
      if (act != exp_v) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
      end
   endtask

   // driver: one vector per cycle, expected item pushed to the scoreboard
   task automatic drive_all();
      for (int v = 0; v < NVEC; v++) begin
         exp_t e;
         logic [NB-1:0] a, b;
         logic [3:0] s;
         logic m, c;
         {m, c, s, b, a} = v[2*NB+5:0];
         @(posedge clk);
         opa = a; opb = b; fsel = s; logic_mode = m; carry_in = c;
         e = model(a, b, s, m, c);
         sb.push_back(e);
      end
      @(posedge clk);
      driver_done = 1'b1;
   endtask

   // monitor: samples at the falling edge, pops and compares
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            string ftag;
            e = sb.pop_front();
            if (e.mode) ftag = e.ci ? "R4 logic result, carry_in=1" : "R1 logic result";
            else ftag = (e.sel == 4'd9) ? "R3 add result" : "R2 arithmetic result";
            check1($sformatf("%s sel=%0d a=%0h b=%0h", ftag, e.sel, e.a, e.b),
                   int'(result), int'(e.f));
            check1($sformatf("R5 carry_out sel=%0d m=%0b a=%0h b=%0h ci=%0b",
                             e.sel, e.mode, e.a, e.b, e.ci), int'(carry_out), int'(e.cout));
            check1($sformatf("R6 grp_gen sel=%0d a=%0h b=%0h", e.sel, e.a, e.b),
                   int'(grp_gen), int'(e.g));
            check1($sformatf("R7 grp_prop sel=%0d a=%0h b=%0h", e.sel, e.a, e.b),
                   int'(grp_prop), int'(e.p));
            // R8: flag; in arithmetic sel 6 with no carry this is the equality compare
            check1($sformatf("R8 a_eq_b sel=%0d m=%0b a=%0h b=%0h ci=%0b",
                             e.sel, e.mode, e.a, e.b, e.ci), int'(a_eq_b), int'(e.eq));
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: all inputs zero gives result A=0 and all flags low
      @(negedge clk);
      check1("R2 reset-state result", int'(result), 0);
      check1("R5 reset-state carry_out", int'(carry_out), 0);
      check1("R8 reset-state a_eq_b", int'(a_eq_b), 0);
      drive_all();
      wait (driver_done && sb.size() == 0);
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule